// File: doc/BRIEF.md
# Comparator Edge Interrupt Debouncer

This block turns the one-bit output of an analog comparator into an edge interrupt flag and keeps noise from setting that flag. The raw bit first passes through a two-flop synchronizer. It is then either sampled on every clock or sampled only on overflow pulses from an external free-running timer. In the overflow-sampled modes, a new level must appear in four consecutive samples before it counts as an edge.

A 2-bit mode field selects one of four behaviours. In two of them, a detected edge is confirmed later. Confirmation waits for the second timer overflow after the edge and then samples the comparator again. The flag is raised only if the comparator still holds the level the edge moved to. Because the timer runs freely, this puts the flag between one and two timer periods after the edge. A 2-bit edge-select field picks the transition direction that counts. The flag stays set until software pulses the clear input.

Top module: `cmp_edge_debounce`

## Requirements
- R1: After reset, `flag_o` is 0, no confirmation is in progress, and the sample history and filtered level are 0.
- R2: In mode 00, the comparator is sampled every clock. A qualifying change on `cmp_i` sets `flag_o` on the third rising clock edge after the change (two synchronizer flops plus the flag register), and not earlier.
- R3: Edge select `edge_sel_i` uses these codes: 00 counts rising edges (new level 1), 01 counts falling edges (new level 0), 10 counts both, and 11 counts none. A non-selected transition never sets the flag.
- R4: In mode 01, the comparator is sampled every clock. A qualifying edge starts a confirmation. The flag is set on the clock that samples the second `tmr_ovf_i` pulse after the edge, and not on the first.
- R5: When a confirmation ends, the synchronized comparator level is compared with the level the edge moved to. If they differ, the event is dropped, no flag is set, and the block returns to idle so that later edges are accepted.
- R6: While a confirmation is in progress, further edges in either direction are ignored. They neither restart the wait nor start a new one after it ends.
- R7: In mode 10, the comparator is sampled only on `tmr_ovf_i` pulses. An edge is captured when four consecutive samples agree and differ from the filtered level. The flag is set on the second overflow after the capturing overflow, provided the level still matches.
- R8: In the overflow-sampled modes (10 and 11), a level seen in fewer than four consecutive overflow samples produces no edge and no flag.
- R9: In mode 11, the comparator is overflow-sampled with the four-sample rule and there is no confirmation wait. The flag is set on the capturing overflow.
- R10: `flag_o` stays set until a `flag_clr_i` pulse, which clears it on the next clock edge. The flag falls only after a clear.
- R11: If a clear and a new acceptance fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Raw comparator output, asynchronous |
| tmr_ovf_i | input | 1 | One-cycle overflow strobe from the free-running timer |
| mode_i | input | 2 | 00 direct, 01 clock-sampled with confirm, 10 overflow-sampled with confirm, 11 overflow-sampled direct |
| edge_sel_i | input | 2 | 00 rising, 01 falling, 10 both, 11 none |
| flag_clr_i | input | 1 | One-cycle flag clear |
| flag_o | output | 1 | Edge interrupt flag |

## Verification
Internal state faults show up at `flag_o` in one of two ways: the flag is missing when it should be set, or it appears on the wrong overflow. A confirmation counter that is off by one sets the flag one overflow pulse early or late, so the flag is checked both after the first and after the second overflow. A busy state that lets new edges through only shows up on later overflows, when a stale restart accepts an edge that should have been dropped. The bench therefore sends extra overflow pulses after each rejection. A fault in the overflow history changes which overflow pulse captures the edge, so the flag is checked after each of the relevant pulses.

// File: rtl/cmp_dbn_pkg.sv
package cmp_dbn_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT      = 2'b00,
    MODE_CLK_CONFIRM = 2'b01,
    MODE_OVF_CONFIRM = 2'b10,
    MODE_OVF_DIRECT  = 2'b11
  } dbn_mode_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_ANY  = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } conf_state_e;

  function automatic logic edge_ok(edge_sel_e sel, logic new_lvl);
    case (sel)
      EDGE_RISE: return new_lvl;
      EDGE_FALL: return !new_lvl;
      EDGE_ANY:  return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cmp_dbn_sync.sv
module cmp_dbn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_dbn_sampler.sv
module cmp_dbn_sampler #(
  parameter int HIST = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic ovf_i,
  input  logic ovf_mode_i,
  output logic evt_o,
  output logic evt_lvl_o
);
  localparam int HW = HIST - 1;

  logic          prev_q;
  logic [HW-1:0] hist_q;
  logic          filt_q;
  logic [HIST-1:0] window;
  logic          stable;
  logic          clk_evt, ovf_evt;

  // per-clock path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end
  assign clk_evt = lvl_i ^ prev_q;

  // overflow-rate path: newest sample plus stored history
  assign window  = {hist_q, lvl_i};
  assign stable  = (&window) | ~(|window);
  assign ovf_evt = ovf_i & stable & (lvl_i != filt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else if (ovf_mode_i && ovf_i) begin
      hist_q <= window[HW-1:0];
      if (ovf_evt) filt_q <= lvl_i;
    end
  end

  assign evt_o     = ovf_mode_i ? ovf_evt : clk_evt;
  assign evt_lvl_o = lvl_i;
endmodule

// File: rtl/cmp_dbn_confirm.sv
module cmp_dbn_confirm
  import cmp_dbn_pkg::*;
#(
  parameter int OVF_CNT = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      evt_i,
  input  logic      evt_lvl_i,
  input  logic      lvl_i,
  input  logic      ovf_i,
  input  logic      wait_en_i,
  input  edge_sel_e edge_sel_i,
  output logic      accept_o,
  output logic      busy_o
);
  localparam int CW = (OVF_CNT > 1) ? $clog2(OVF_CNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVF_CNT - 1);

  conf_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;
  logic          qual;

  assign qual = evt_i & edge_ok(edge_sel_i, evt_lvl_i);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    exp_d    = exp_q;
    accept_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (qual) begin
          if (wait_en_i) begin
            state_d = ST_WAIT;
            cnt_d   = '0;
            exp_d   = evt_lvl_i;
          end else begin
            accept_o = 1'b1;
          end
        end
      end
      default: begin
        // edges ignored until the wait resolves
        if (ovf_i) begin
          if (cnt_q == LAST) begin
            accept_o = (lvl_i == exp_q);
            state_d  = ST_IDLE;
            cnt_d    = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      exp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      exp_q   <= exp_d;
    end
  end

  assign busy_o = (state_q == ST_WAIT);
endmodule

// File: rtl/cmp_edge_debounce.sv
module cmp_edge_debounce
  import cmp_dbn_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HIST_LEN    = 4,
  parameter int CONFIRM_OVF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmp_i,
  input  logic       tmr_ovf_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] edge_sel_i,
  input  logic       flag_clr_i,
  output logic       flag_o
);
  dbn_mode_e mode;
  logic      cmp_s;
  logic      ovf_mode, wait_en;
  logic      evt_w, evt_lvl_w;
  logic      accept_w, busy_w;
  logic      flag_q;

  assign mode     = dbn_mode_e'(mode_i);
  assign ovf_mode = (mode == MODE_OVF_CONFIRM) || (mode == MODE_OVF_DIRECT);
  assign wait_en  = (mode == MODE_CLK_CONFIRM) || (mode == MODE_OVF_CONFIRM);

  cmp_dbn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  cmp_dbn_sampler #(.HIST(HIST_LEN)) u_sampler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (cmp_s),
    .ovf_i     (tmr_ovf_i),
    .ovf_mode_i(ovf_mode),
    .evt_o     (evt_w),
    .evt_lvl_o (evt_lvl_w)
  );

  cmp_dbn_confirm #(.OVF_CNT(CONFIRM_OVF)) u_confirm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_w),
    .evt_lvl_i (evt_lvl_w),
    .lvl_i     (cmp_s),
    .ovf_i     (tmr_ovf_i),
    .wait_en_i (wait_en),
    .edge_sel_i(edge_sel_e'(edge_sel_i)),
    .accept_o  (accept_w),
    .busy_o    (busy_w)
  );

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (accept_w)   flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cmp_edge_debounce_chk.sv
module cmp_edge_debounce_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tmr_ovf_i,
  input logic [1:0] mode_i,
  input logic [1:0] edge_sel_i,
  input logic       flag_clr_i,
  input logic       flag_o,
  input logic       accept_i,
  input logic       busy_i
);
  // R10: flag only drops after a clear
  p_fall_needs_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(flag_clr_i));

  // R11: acceptance always leaves the flag set
  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> flag_o);

  // R4: confirmed modes accept only on an overflow
  p_confirm_on_ovf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && (mode_i == 2'b01 || mode_i == 2'b10)) |-> tmr_ovf_i);

  // R9: overflow-sampled modes accept only on an overflow
  p_ovf_mode_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && mode_i[1]) |-> tmr_ovf_i);

  // R6: a wait only ends on an overflow
  p_wait_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !tmr_ovf_i) |=> busy_i);

  // R3: edge select 11 never starts anything
  p_sel_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == 2'b11 && !busy_i) |-> !accept_i);

  // R3: with edge select 11, an idle block stays idle
  p_sel_off_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == 2'b11 && !busy_i) |=> !busy_i);
endmodule

bind cmp_edge_debounce cmp_edge_debounce_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tmr_ovf_i (tmr_ovf_i),
  .mode_i    (mode_i),
  .edge_sel_i(edge_sel_i),
  .flag_clr_i(flag_clr_i),
  .flag_o    (flag_o),
  .accept_i  (accept_w),
  .busy_i    (busy_w)
);

// File: tb/cmp_edge_debounce_tb.sv
module cmp_edge_debounce_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp = 1'b0;
  logic       tmr_ovf = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] edge_sel = 2'b00;
  logic       flag_clr = 1'b0;
  logic       flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t sb_q[$];
  event  chk_ev;

  always #10 clk = ~clk;

  cmp_edge_debounce u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cmp_i     (cmp),
    .tmr_ovf_i (tmr_ovf),
    .mode_i    (mode),
    .edge_sel_i(edge_sel),
    .flag_clr_i(flag_clr),
    .flag_o    (flag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_flag(input logic exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic ovf_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      tmr_ovf = 1'b1;
      tick(1);
      tmr_ovf = 1'b0;
    end
  endtask

  task automatic clr_pulse();
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
  endtask

  task automatic reset_dut(input logic [1:0] m, input logic [1:0] s);
    rst_n = 1'b0;
    cmp = 1'b0; tmr_ovf = 1'b0; flag_clr = 1'b0;
    mode = m; edge_sel = s;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  // monitor: pops expected items and compares with the port
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (flag !== it.exp) begin
          errors++;
          $display("FAIL %s flag_o=%0b expected=%0b", it.tag, flag, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog flag_o=%0b expected=finish", flag);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(1);
    expect_flag(1'b0, "R1 flag during reset");
    reset_dut(2'b00, 2'b00);
    expect_flag(1'b0, "R1 flag after reset");

    // R2: direct mode latency
    cmp = 1'b1;
    tick(2);
    expect_flag(1'b0, "R2 not before third edge");
    tick(1);
    expect_flag(1'b1, "R2 set on third edge");
    tick(5);
    expect_flag(1'b1, "R10 flag holds");
    clr_pulse();
    expect_flag(1'b0, "R10 clear");

    // R3: rising select ignores fall
    cmp = 1'b0;
    tick(4);
    expect_flag(1'b0, "R3 fall ignored on rise select");
    edge_sel = 2'b01;
    cmp = 1'b1;
    tick(4);
    expect_flag(1'b0, "R3 rise ignored on fall select");
    cmp = 1'b0;
    tick(3);
    expect_flag(1'b1, "R3 fall accepted on fall select");
    clr_pulse();
    edge_sel = 2'b11;
    cmp = 1'b1; tick(4); cmp = 1'b0; tick(4);
    expect_flag(1'b0, "R3 select off");
    edge_sel = 2'b10;
    cmp = 1'b1; tick(3);
    expect_flag(1'b1, "R3 both select rise");
    clr_pulse();
    cmp = 1'b0; tick(3);
    expect_flag(1'b1, "R3 both select fall");
    clr_pulse();

    // R11: clear and accept in the same cycle
    cmp = 1'b1;
    tick(2);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    expect_flag(1'b1, "R11 set beats clear");
    clr_pulse();

    // R4: clock-sampled confirm
    reset_dut(2'b01, 2'b00);
    cmp = 1'b1;
    tick(3);
    ovf_pulse(1);
    expect_flag(1'b0, "R4 not on first overflow");
    ovf_pulse(1);
    expect_flag(1'b1, "R4 set on second overflow");
    clr_pulse();

    // R5: rejection, then recovery
    reset_dut(2'b01, 2'b00);
    cmp = 1'b1; tick(3);
    ovf_pulse(1);
    cmp = 1'b0; tick(3);
    ovf_pulse(1);
    expect_flag(1'b0, "R5 mismatch rejected");
    cmp = 1'b1; tick(3);
    ovf_pulse(2);
    expect_flag(1'b1, "R5 idle again after reject");
    clr_pulse();

    // R6: edges during wait ignored
    reset_dut(2'b01, 2'b10);
    cmp = 1'b1; tick(3);
    cmp = 1'b0; tick(3);
    ovf_pulse(2);
    expect_flag(1'b0, "R6 wait rejects original edge");
    ovf_pulse(2);
    expect_flag(1'b0, "R6 fall during wait started nothing");

    // R7: overflow-sampled confirm
    reset_dut(2'b10, 2'b00);
    cmp = 1'b1; tick(3);
    ovf_pulse(3);
    expect_flag(1'b0, "R7 three samples not yet edge");
    ovf_pulse(1);
    expect_flag(1'b0, "R7 capture overflow no flag");
    ovf_pulse(1);
    expect_flag(1'b0, "R7 first overflow after capture");
    ovf_pulse(1);
    expect_flag(1'b1, "R7 second overflow after capture");
    clr_pulse();

    // R8: short level rejected
    reset_dut(2'b10, 2'b00);
    cmp = 1'b1; tick(3);
    ovf_pulse(3);
    cmp = 1'b0; tick(3);
    ovf_pulse(6);
    expect_flag(1'b0, "R8 three-sample level rejected");

    // R9: overflow-sampled direct
    reset_dut(2'b11, 2'b00);
    cmp = 1'b1; tick(3);
    ovf_pulse(3);
    expect_flag(1'b0, "R9 before fourth sample");
    ovf_pulse(1);
    expect_flag(1'b1, "R9 set on capturing overflow");

    tick(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule